// File: doc/BRIEF.md
# Nested Vectored Priority Interrupt Controller

This block collects up to 32 interrupt inputs and presents one active-low interrupt request to a processor. Each input has its own priority (eight levels), trigger mode (level or rising edge), enable bit and handler vector. Software programs these settings through a simple word-addressed register bus.

To take an interrupt, software reads the take register. That read has side effects. It selects the highest-priority eligible source and returns that source's vector. It also pushes the source number and priority onto an eight-entry nesting stack, which drops the request. For an edge-triggered source, it clears the latched edge. A write to the end-of-interrupt register pops the stack. The request is raised again only for a source of strictly higher priority than the one at the top of the stack, so handlers nest up to eight deep.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With the default parameters the bus decodes the following addresses.
  - Address 0x00+n is source n's config register: bits [2:0] priority, bit 3 edge mode (1 = rising edge, 0 = level), bit 4 enable.
  - Address 0x20+n holds source n's vector.
  - Address 0x42 holds the spurious vector, which is 0 after reset.
  - These registers read back what was written.
  - Read data appears on `bus_rdata` in the cycle after `bus_rd`, and it is 0 after reset.
- R2: `irq_n` is low exactly when some enabled, pending source has a priority above the current level, where an empty stack counts as below level 0. A disabled source never asserts it.
- R3: A read of 0x40 returns the vector of the eligible source with the highest priority. When priorities are equal, the lower source number wins.
- R4: A read of 0x40 that selects a source makes its priority the current level. As a result, `irq_n` goes high right after the read, unless a strictly higher source is eligible.
- R5: While a source is being serviced, a new enabled source of higher priority pulls `irq_n` low. A source of equal or lower priority does not.
- R6: A write to 0x41 pops the stack and restores the previous current level. A write to 0x41 with an empty stack has no effect.
- R7: Pending state depends on the trigger mode.
  - A level source stays pending while its input is high.
  - An edge source latches a rising edge of its synchronized input and stays pending after the input falls.
  - The latched edge is cleared when a read of 0x40 selects that source.
- R8: A read of 0x40 when no source can raise `irq_n` returns the spurious vector and pushes nothing.
- R9: Eight interrupts of rising priority nest eight deep. Eight end-of-interrupt writes then empty the stack again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Raw interrupt inputs, active high, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench checks the following corner cases and what a faulty design would do in each:
- Equal-priority ties: a design that picks the wrong source returns the higher-numbered vector.
- Equal and lower priorities arriving during service: a design that compares with "greater or equal" re-raises the request for them.
- Restoring the old level after a pop: a design that fails to restore it keeps the request high when an intermediate-priority source is waiting.
- Edge sources: an edge source that never clears keeps requesting after it is serviced.
- Empty-stack end-of-interrupt: a pointer that underflows turns a later nested source into a false request.
- Full eight-deep nesting followed by a spurious take: a design that pushes on a spurious take loses track of the nesting depth.

// File: rtl/prio_irq_pkg.sv
// Package: shared register-region type for the interrupt controller.
// Assumes word addressing; offsets are derived in the top from the source count.
package prio_irq_pkg;
    typedef enum logic [2:0] {
        REG_CFG,
        REG_VEC,
        REG_TAKE,
        REG_EOI,
        REG_SPUR,
        REG_NONE
    } reg_region_t;
endpackage

// File: rtl/irq_src_latch.sv
// One interrupt input: two-flop synchronizer, rising-edge detector and edge latch.
// Assumes src_raw is asynchronous. pend follows the synchronized level in level
// mode and the edge latch in edge mode; clr removes a latched edge.
module irq_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_raw,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic sync1, sync2, prev, edge_q, rise;

    assign rise = sync2 & ~prev;

    // Synchronize the input and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= src_raw;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Latch a rising edge until it is taken; a fresh edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      edge_q <= 1'b0;
        else if (rise)   edge_q <= 1'b1;
        else if (clr)    edge_q <= 1'b0;
    end

    assign pend = edge_mode ? edge_q : sync2;

    // R7: a take without a new edge empties the latch.
    a_r7_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !edge_q);
    // R7: a latched edge persists until taken.
    a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_q && !clr) |=> edge_q);
endmodule

// File: rtl/irq_arbiter.sv
// Combinational priority search over all sources.
// Assumes priorities are unsigned (larger = more urgent); ties go to the lower index.
module irq_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = 3,
    parameter int IDX_W   = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               elig,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]    pri,
    output logic                             any,
    output logic [IDX_W-1:0]                 best_idx,
    output logic [LVL_W-1:0]                 best_pri
);
    // Scan upward; only a strictly greater priority displaces the holder.
    always_comb begin
        any      = 1'b0;
        best_idx = '0;
        best_pri = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!any || pri[i] > best_pri)) begin
                any      = 1'b1;
                best_idx = IDX_W'(i);
                best_pri = pri[i];
            end
        end
    end

    // R3: the winner is itself eligible and carries its own priority.
    a_r3_winner_valid: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (elig[best_idx] && pri[best_idx] == best_pri));
    // R2: no eligible source means no winner.
    a_r2_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> !any);
endmodule

// File: rtl/irq_nest_stack.sv
// Nesting stack of (source number, priority level) pairs.
// Assumes push and pop are never asserted together; a push when full and a
// pop when empty are dropped.
module irq_nest_stack #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 5,
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [LVL_W-1:0] push_lvl,
    output logic             empty,
    output logic             full,
    output logic [IDX_W-1:0] top_idx,
    output logic [LVL_W-1:0] top_lvl
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  top_ptr;
    logic [IDX_W-1:0] idx_mem [DEPTH];
    logic [LVL_W-1:0] lvl_mem [DEPTH];

    assign empty   = (sp == '0);
    assign full    = (sp == SP_W'(DEPTH));
    assign top_ptr = sp - 1'b1;
    assign top_idx = empty ? '0 : idx_mem[top_ptr[PTR_W-1:0]];
    assign top_lvl = empty ? '0 : lvl_mem[top_ptr[PTR_W-1:0]];

    // Move the stack pointer on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)              sp <= '0;
        else if (push && !full)  sp <= sp + 1'b1;
        else if (pop && !empty)  sp <= sp - 1'b1;
    end

    // Store the pushed pair at the free slot.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            idx_mem[sp[PTR_W-1:0]] <= push_idx;
            lvl_mem[sp[PTR_W-1:0]] <= push_lvl;
        end
    end

    // R6: popping an empty stack leaves it empty.
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);
    // R9: the pointer never passes the depth.
    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SP_W'(DEPTH));
    // R4: an accepted push makes the pushed level current.
    a_r4_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (!empty && top_lvl == $past(push_lvl)));
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top: register file, per-source latches, arbitration, nesting stack and
// active-low request. Assumes one bus access per cycle (bus_rd and bus_wr
// exclusive) and NUM_SRC + NUM_SRC + 3 addresses fitting in ADDR_W bits.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_LVL   = 8,
    parameter int NEST_DEPTH = 8,
    parameter int VEC_W     = 32,
    parameter int ADDR_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [VEC_W-1:0]   bus_wdata,
    output logic [VEC_W-1:0]   bus_rdata,
    output logic               irq_n
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int LVL_W = $clog2(NUM_LVL);
    localparam logic [ADDR_W-1:0] VEC_BASE  = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] TAKE_ADDR = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] EOI_ADDR  = ADDR_W'(2 * NUM_SRC + 1);
    localparam logic [ADDR_W-1:0] SPUR_ADDR = ADDR_W'(2 * NUM_SRC + 2);
    localparam int EDGE_BIT = LVL_W;
    localparam int EN_BIT   = LVL_W + 1;

    reg_region_t                    region;
    logic [ADDR_W-1:0]              vec_off;
    logic [IDX_W-1:0]               sel;
    logic [NUM_SRC-1:0][LVL_W-1:0]  cfg_pri;
    logic [NUM_SRC-1:0]             cfg_edge, cfg_en, pend, clr;
    logic [VEC_W-1:0]               vec_mem [NUM_SRC];
    logic [VEC_W-1:0]               spur_vec, cfg_word;
    logic                           any, req, take, push, pop;
    logic                           st_empty, st_full;
    logic [IDX_W-1:0]               best_idx, top_idx;
    logic [LVL_W-1:0]               best_pri, top_lvl;

    // Classify the bus address into a register region.
    always_comb begin
        if (bus_addr < VEC_BASE)        region = REG_CFG;
        else if (bus_addr < TAKE_ADDR)  region = REG_VEC;
        else if (bus_addr == TAKE_ADDR) region = REG_TAKE;
        else if (bus_addr == EOI_ADDR)  region = REG_EOI;
        else if (bus_addr == SPUR_ADDR) region = REG_SPUR;
        else                            region = REG_NONE;
    end

    assign vec_off = bus_addr - VEC_BASE;
    assign sel     = (region == REG_VEC) ? vec_off[IDX_W-1:0] : bus_addr[IDX_W-1:0];

    // Config and spurious-vector registers, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_pri  <= '0;
            cfg_edge <= '0;
            cfg_en   <= '0;
            spur_vec <= '0;
        end else if (bus_wr) begin
            if (region == REG_CFG) begin
                cfg_pri[sel]  <= bus_wdata[LVL_W-1:0];
                cfg_edge[sel] <= bus_wdata[EDGE_BIT];
                cfg_en[sel]   <= bus_wdata[EN_BIT];
            end else if (region == REG_SPUR) begin
                spur_vec <= bus_wdata;
            end
        end
    end

    // Handler vector storage, written from the bus.
    always_ff @(posedge clk) begin
        if (bus_wr && region == REG_VEC) vec_mem[sel] <= bus_wdata;
    end

    // Assemble the config readback word.
    always_comb begin
        cfg_word                 = '0;
        cfg_word[LVL_W-1:0]      = cfg_pri[sel];
        cfg_word[EDGE_BIT]       = cfg_edge[sel];
        cfg_word[EN_BIT]         = cfg_en[sel];
    end

    // Per-source synchronizer and pending logic.
    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign clr[g] = push && (best_idx == IDX_W'(g));
            irq_src_latch u_latch (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_raw   (src_in[g]),
                .edge_mode (cfg_edge[g]),
                .clr       (clr[g]),
                .pend      (pend[g])
            );
        end
    endgenerate

    irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (pend & cfg_en),
        .pri      (cfg_pri),
        .any      (any),
        .best_idx (best_idx),
        .best_pri (best_pri)
    );

    // A request stands when the winner outranks the level being serviced.
    assign req   = any && !st_full && (st_empty || best_pri > top_lvl);
    assign irq_n = ~req;
    assign take  = bus_rd && region == REG_TAKE;
    assign push  = take && req;
    assign pop   = bus_wr && region == REG_EOI;

    irq_nest_stack #(.DEPTH(NEST_DEPTH), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_idx (best_idx),
        .push_lvl (best_pri),
        .empty    (st_empty),
        .full     (st_full),
        .top_idx  (top_idx),
        .top_lvl  (top_lvl)
    );

    // Registered read data; a take returns the winner's vector or the spurious one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (region)
                REG_CFG:  bus_rdata <= cfg_word;
                REG_VEC:  bus_rdata <= vec_mem[sel];
                REG_TAKE: bus_rdata <= req ? vec_mem[best_idx] : spur_vec;
                REG_SPUR: bus_rdata <= spur_vec;
                default:  bus_rdata <= '0;
            endcase
        end
    end

    // R2: a low request always has an enabled pending source behind it.
    a_r2_req_backed: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((pend & cfg_en) != '0));
    // R8: a take with no request leaves the stack as it was.
    a_r8_spur_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (take && irq_n && st_empty) |=> st_empty);
    // R4: a push leaves the serviced source at the top of the stack.
    a_r4_top_source: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_idx == $past(best_idx)));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_in;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [7:0]  TAKE = 8'h40;
    localparam logic [7:0]  EOI  = 8'h41;
    localparam logic [7:0]  SPUR = 8'h42;
    localparam logic [31:0] SPV  = 32'hDEAD_0000;

    // {source pattern, expected take vector, request expected}
    localparam logic [64:0] TBL [5] = '{
        {32'h0000_0002, 32'h0000_1001, 1'b1},
        {32'h0000_0808, 32'h0000_1003, 1'b1},
        {32'h0000_00A0, 32'h0000_1007, 1'b1},
        {32'h0001_0004, 32'h0000_1002, 1'b1},
        {32'h0000_0000, SPV,           1'b0}
    };

    always #5 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        wait_cyc(4);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; src_in = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset irq_n", 32'(irq_n), 32'd1);
        check("R1 reset rdata", bus_rdata, 32'd0);
        bus_read(SPUR, d);
        check("R1 reset spurious", d, 32'd0);

        // Program: source i level-triggered, enabled, priority i%8, vector 0x1000+i.
        for (int i = 0; i < 32; i++) begin
            bus_write(8'(i), 32'h10 | 32'(i % 8));
            bus_write(8'(32 + i), 32'h1000 + 32'(i));
        end
        bus_write(SPUR, SPV);
        bus_read(8'h05, d);  check("R1 cfg readback", d, 32'h15);
        bus_read(8'h2A, d);  check("R1 vec readback", d, 32'h100A);
        bus_read(SPUR, d);   check("R1 spurious readback", d, SPV);

        // Table walk: arbitration over several patterns (R2, R3, R4, R8).
        for (int t = 0; t < 5; t++) begin
            set_src(TBL[t][64:33]);
            check("R2 request", 32'(irq_n), 32'(!TBL[t][0]));
            bus_read(TAKE, d);
            check("R3 take vector", d, TBL[t][32:1]);
            check("R4 request dropped", 32'(irq_n), 32'd1);
            set_src('0);
            if (TBL[t][0]) bus_write(EOI, '0);
            check("R6 idle after eoi", 32'(irq_n), 32'd1);
        end

        // Disabled source is ignored (R2, R8).
        bus_write(8'h09, 32'h1);
        set_src(32'h200);
        check("R2 disabled no request", 32'(irq_n), 32'd1);
        bus_read(TAKE, d);
        check("R8 spurious on disabled", d, SPV);
        set_src('0);

        // Nesting and restore (R5, R6, R7 level).
        set_src(32'h4);
        check("R2 src2 request", 32'(irq_n), 32'd0);
        bus_read(TAKE, d);   check("R3 src2 vector", d, 32'h1002);
        check("R4 drop after take", 32'(irq_n), 32'd1);
        set_src(32'h44);
        check("R5 higher reasserts", 32'(irq_n), 32'd0);
        bus_read(TAKE, d);   check("R5 nested vector", d, 32'h1006);
        set_src(32'h14);
        check("R5 lower ignored", 32'(irq_n), 32'd1);
        bus_write(EOI, '0);
        check("R6 restored level", 32'(irq_n), 32'd0);
        bus_read(TAKE, d);   check("R6 src4 vector", d, 32'h1004);
        set_src(32'h4);
        bus_write(EOI, '0);
        check("R5 equal ignored", 32'(irq_n), 32'd1);
        bus_write(EOI, '0);
        check("R7 level still pending", 32'(irq_n), 32'd0);
        set_src('0);
        check("R7 level gone", 32'(irq_n), 32'd1);
        bus_write(EOI, '0);
        set_src(32'h4);
        bus_read(TAKE, d);   check("R6 take after empty eoi", d, 32'h1002);
        set_src(32'h6);
        check("R6 empty eoi ignored", 32'(irq_n), 32'd1);
        set_src('0);
        bus_write(EOI, '0);

        // Edge-triggered source 20 (R7).
        bus_write(8'd20, 32'h1B);
        @(negedge clk); src_in = 32'h0010_0000;
        @(negedge clk); src_in = '0;
        wait_cyc(4);
        check("R7 edge latched", 32'(irq_n), 32'd0);
        bus_read(TAKE, d);   check("R7 edge vector", d, 32'h1014);
        bus_write(EOI, '0);
        wait_cyc(2);
        check("R7 edge cleared", 32'(irq_n), 32'd1);

        // Eight-deep nesting (R9, R8).
        d = '0;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            set_src(32'hFF >> (7 - i));
            bus_read(TAKE, v);
            check("R9 nested vector", v, 32'h1000 + 32'(i));
        end
        bus_read(TAKE, d);
        check("R8 spurious at full depth", d, SPV);
        check("R9 no request at full depth", 32'(irq_n), 32'd1);
        set_src('0);
        for (int i = 0; i < 8; i++) bus_write(EOI, '0);
        set_src(32'h1);
        check("R9 stack emptied", 32'(irq_n), 32'd0);
        set_src('0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule